// File: doc/BRIEF.md
# Two- and Three-Level Page Table Walker with A20 Gating

This block turns a 32-bit linear address into a physical address by reading page-table entries from memory. Its caller pulses a start strobe with the linear address and a snapshot of the paging controls: paging enable, the table base register, the extended-format enable and the large-page enable. The walker then fetches entries one at a time over a valid/ready request port and a response port. One format uses two levels of 32-bit entries, with an optional 4 MB page at the directory level. The other uses three levels of 64-bit entries, with a 2 MB page at the directory level or 4 KB pages at the table level. When the walk completes, the block pulses done with the physical address, a page size code and a fault flag.

Every table fetch address, and the frame taken from the final entry, is ANDed with an address-line-20 gating mask. The mask is a 32-bit register that resets to all ones and is sign-extended to the physical width. While the system-management input is high at start, the mask for that whole walk is forced to all ones. This lets firmware running in that mode see memory above 1 MB no matter how the gate is set.

Top module: `pt_walker`

## Requirements
- R1: After reset, done and mem_req_valid are low, and the gating mask register holds all ones, so bit 20 of an address passes through.
- R2: With paging disabled, no memory request is issued, and the result is the linear address ANDed with the effective mask, with page size code 0 (4 KB) and no fault.
- R3: The effective mask for a walk is sampled at start. It is all ones when smm_mode is high, and otherwise it is the programmed mask sign-extended to PA_W bits. It applies to every fetch address of that walk.
- R4: In the two-level format, the first fetch is a 32-bit read (mem_req_wide=0) at ((cr3 with bits 11:0 cleared) + ((lin >> 20) & 0xFFC)) ANDed with the mask. The upper 32 bits of the response are ignored.
- R5: In the two-level format, the table fetch is a 32-bit read at ((directory entry with bits 11:0 cleared) + ((lin >> 10) & 0xFFC)) ANDed with the mask, and a present entry there gives a 4 KB page.
- R6: In the two-level format, a directory entry with bit 7 set gives a 4 MB page and ends the walk only when the large-page enable is high. Otherwise bit 7 is ignored and the table fetch follows.
- R7: In the three-level format, every fetch is a 64-bit read (mem_req_wide=1), and the first fetch is at ((cr3 with bits 4:0 cleared) + ((lin >> 27) & 0x18)) ANDed with the mask.
- R8: In the three-level format, the directory and table fetch addresses are the previous entry's bits PA_W-1:12 (as an address) plus lin[29:21]*8 and lin[20:12]*8 respectively, ANDed with the mask. A directory entry with bit 7 set gives a 2 MB page.
- R9: A fetched entry with bit 0 clear ends the walk at once with fault=1, phys_addr=0 and page size code 0, and no further fetch is issued.
- R10: The result is ((final entry AND mask) with the bits below the page size cleared) OR (the linear address bits below the page size). Page size codes are 0=4 KB, 1=2 MB, 2=4 MB.
- R11: mem_req_valid stays high with a stable address and size flag until mem_req_ready. At most one fetch is outstanding, and done is a single-cycle pulse per walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a20_wr_en | input | 1 | Write strobe for the gating mask register |
| a20_wr_data | input | 32 | New gating mask value |
| start | input | 1 | Begin a walk (ignored while one is running) |
| lin_addr | input | 32 | Linear address to translate |
| cr0_pg | input | 1 | Paging enable |
| cr3 | input | 32 | Table base register |
| cr4_pae | input | 1 | Select the three-level 64-bit-entry format |
| cr4_pse | input | 1 | Allow 4 MB pages in the two-level format |
| smm_mode | input | 1 | System-management mode; bypasses the gate |
| mem_req_valid | output | 1 | Fetch request valid |
| mem_req_ready | input | 1 | Fetch request accepted |
| mem_req_addr | output | PA_W | Fetch physical address |
| mem_req_wide | output | 1 | 1 = 64-bit read, 0 = 32-bit read |
| mem_rsp_valid | input | 1 | Fetch data valid |
| mem_rsp_data | input | 64 | Fetch data |
| done | output | 1 | Result valid pulse |
| phys_addr | output | PA_W | Translated physical address |
| page_size | output | 2 | Page size code |
| fault | output | 1 | Not-present fault |

## Verification
The walker is exercised with paging off, with a cleared gate bit, and with the gate bypassed. These three cases separate the reset mask, the programmed mask and the system-management override. Two-level walks run with and without the large-page enable on the same directory entry, which shows whether bit 7 is honoured only when allowed. Three-level walks that end at 2 MB and at 4 KB, one with a frame above 4 GB, check the 64-bit path and the index fields. Faults injected at the first and second levels confirm that the walk stops without issuing more fetches. One walk has its directory pointer placed above 1 MB so that only the gated address hits a valid entry; with the gate bypassed, the same walk faults.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    LV_PDPT = 2'd0,
    LV_PD   = 2'd1,
    LV_PT   = 2'd2
  } lvl_e;

  typedef enum logic [1:0] {
    SZ_4K = 2'd0,
    SZ_2M = 2'd1,
    SZ_4M = 2'd2
  } psize_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CALC = 3'd1,
    ST_REQ  = 3'd2,
    ST_WAIT = 3'd3,
    ST_FIN  = 3'd4
  } wstate_e;

  localparam int LIN_W   = 32;
  localparam int ENTRY_W = 64;
  localparam int GATE_BIT = 20;
  localparam int PS_BIT  = 7;

endpackage

// File: rtl/pgw_a20.sv
module pgw_a20 #(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  input  logic            bypass,
  output logic [PA_W-1:0] eff_mask
);
  logic [31:0]     gate_q;
  logic [PA_W-1:0] gate_ext;

  always_ff @(posedge clk) begin
    if (rst)        gate_q <= '1;
    else if (wr_en) gate_q <= wr_data;
  end

  generate
    if (PA_W > 32) begin : g_sext
      assign gate_ext = {{(PA_W-32){gate_q[31]}}, gate_q};
    end else begin : g_trunc
      assign gate_ext = gate_q[PA_W-1:0];
    end
  endgenerate

  assign eff_mask = bypass ? '1 : gate_ext;
endmodule

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen
  import pgw_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  lvl_e            lvl,
  input  logic            pae,
  input  logic [31:0]     cr3,
  input  logic [31:0]     lin,
  input  logic [PA_W-1:0] entry,
  input  logic [PA_W-1:0] mask,
  output logic [PA_W-1:0] addr
);
  localparam logic [PA_W-1:0] FRAME_M = {{(PA_W-12){1'b1}}, 12'h000};

  logic [PA_W-1:0] base;
  logic [PA_W-1:0] offs;

  always_comb begin
    base = '0;
    offs = '0;
    case (lvl)
      LV_PDPT: begin
        base = PA_W'(cr3 & ~32'h1F);
        offs = PA_W'((lin >> 27) & 32'h18);
      end
      LV_PD: begin
        if (pae) begin
          base = entry & FRAME_M;
          offs = PA_W'({lin[29:21], 3'b000});
        end else begin
          base = PA_W'(cr3 & ~32'hFFF);
          offs = PA_W'((lin >> 20) & 32'hFFC);
        end
      end
      LV_PT: begin
        if (pae) begin
          base = entry & FRAME_M;
          offs = PA_W'({lin[20:12], 3'b000});
        end else begin
          base = PA_W'(entry[31:0] & ~32'hFFF);
          offs = PA_W'((lin >> 10) & 32'hFFC);
        end
      end
      default: begin
        base = '0;
        offs = '0;
      end
    endcase
    addr = (base + offs) & mask;
  end
endmodule

// File: rtl/pgw_leaf_map.sv
module pgw_leaf_map
  import pgw_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic            pg,
  input  logic            pae,
  input  lvl_e            lvl,
  input  logic [PA_W-1:0] entry,
  input  logic [31:0]     lin,
  input  logic [PA_W-1:0] mask,
  output logic [PA_W-1:0] phys,
  output psize_e          size
);
  localparam logic [PA_W-1:0] OFF_4K = PA_W'(32'h0000_0FFF);
  localparam logic [PA_W-1:0] OFF_2M = PA_W'(32'h001F_FFFF);
  localparam logic [PA_W-1:0] OFF_4M = PA_W'(32'h003F_FFFF);

  logic [PA_W-1:0] off_m;
  logic [PA_W-1:0] lin_x;

  assign lin_x = PA_W'(lin);

  always_comb begin
    if (!pg) begin
      size  = SZ_4K;
      off_m = OFF_4K;
      phys  = lin_x & mask;
    end else begin
      if (lvl == LV_PT) begin
        size  = SZ_4K;
        off_m = OFF_4K;
      end else if (pae) begin
        size  = SZ_2M;
        off_m = OFF_2M;
      end else begin
        size  = SZ_4M;
        off_m = OFF_4M;
      end
      phys = ((entry & mask) & ~off_m) | (lin_x & off_m);
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pgw_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            a20_wr_en,
  input  logic [31:0]     a20_wr_data,
  input  logic            start,
  input  logic [31:0]     lin_addr,
  input  logic            cr0_pg,
  input  logic [31:0]     cr3,
  input  logic            cr4_pae,
  input  logic            cr4_pse,
  input  logic            smm_mode,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [PA_W-1:0] mem_req_addr,
  output logic            mem_req_wide,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            done,
  output logic [PA_W-1:0] phys_addr,
  output logic [1:0]      page_size,
  output logic            fault
);
  wstate_e         state_q;
  lvl_e            lvl_q;
  logic [31:0]     lin_q;
  logic [31:0]     cr3_q;
  logic            pg_q, pae_q, pse_q;
  logic [PA_W-1:0] mask_q;
  logic [PA_W-1:0] entry_q;
  logic            flt_q;

  logic            req_valid_q;
  logic [PA_W-1:0] req_addr_q;
  logic            req_wide_q;
  logic            done_q, fault_q;
  logic [PA_W-1:0] phys_q;
  logic [1:0]      size_q;

  logic [PA_W-1:0] eff_mask;
  logic [PA_W-1:0] fetch_addr;
  logic [PA_W-1:0] leaf_phys;
  psize_e          leaf_size;
  logic [63:0]     rsp_word;
  logic            rsp_leaf;
  logic            unused_hi;

  pgw_a20 #(.PA_W(PA_W)) u_a20 (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (a20_wr_en),
    .wr_data  (a20_wr_data),
    .bypass   (smm_mode),
    .eff_mask (eff_mask)
  );

  pgw_addr_gen #(.PA_W(PA_W)) u_addr (
    .lvl   (lvl_q),
    .pae   (pae_q),
    .cr3   (cr3_q),
    .lin   (lin_q),
    .entry (entry_q),
    .mask  (mask_q),
    .addr  (fetch_addr)
  );

  pgw_leaf_map #(.PA_W(PA_W)) u_leaf (
    .pg    (pg_q),
    .pae   (pae_q),
    .lvl   (lvl_q),
    .entry (entry_q),
    .lin   (lin_q),
    .mask  (mask_q),
    .phys  (leaf_phys),
    .size  (leaf_size)
  );

  // 32-bit fetches drop the upper response half
  assign rsp_word  = pae_q ? mem_rsp_data : {32'h0, mem_rsp_data[31:0]};
  assign unused_hi = ^rsp_word[63:PA_W];
  assign rsp_leaf  = (lvl_q == LV_PT) ||
                     ((lvl_q == LV_PD) && rsp_word[PS_BIT] && (pae_q || pse_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lvl_q       <= LV_PD;
      lin_q       <= '0;
      cr3_q       <= '0;
      pg_q        <= 1'b0;
      pae_q       <= 1'b0;
      pse_q       <= 1'b0;
      mask_q      <= '1;
      entry_q     <= '0;
      flt_q       <= 1'b0;
      req_valid_q <= 1'b0;
      req_addr_q  <= '0;
      req_wide_q  <= 1'b0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      phys_q      <= '0;
      size_q      <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            lin_q   <= lin_addr;
            cr3_q   <= cr3;
            pg_q    <= cr0_pg;
            pae_q   <= cr4_pae;
            pse_q   <= cr4_pse;
            mask_q  <= eff_mask;
            entry_q <= '0;
            flt_q   <= 1'b0;
            lvl_q   <= cr4_pae ? LV_PDPT : LV_PD;
            state_q <= cr0_pg ? ST_CALC : ST_FIN;
          end
        end
        ST_CALC: begin
          req_addr_q  <= fetch_addr;
          req_wide_q  <= pae_q;
          req_valid_q <= 1'b1;
          state_q     <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_req_ready) begin
            req_valid_q <= 1'b0;
            state_q     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            entry_q <= rsp_word[PA_W-1:0];
            if (!rsp_word[0]) begin
              flt_q   <= 1'b1;
              state_q <= ST_FIN;
            end else if (rsp_leaf) begin
              state_q <= ST_FIN;
            end else begin
              lvl_q   <= (lvl_q == LV_PDPT) ? LV_PD : LV_PT;
              state_q <= ST_CALC;
            end
          end
        end
        ST_FIN: begin
          done_q  <= 1'b1;
          fault_q <= flt_q;
          phys_q  <= flt_q ? '0 : leaf_phys;
          size_q  <= flt_q ? SZ_4K : leaf_size;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = req_valid_q;
  assign mem_req_addr  = req_addr_q;
  assign mem_req_wide  = req_wide_q;
  assign done          = done_q;
  assign phys_addr     = phys_q;
  assign page_size     = size_q;
  assign fault         = fault_q;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wide))); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_NO_FETCH_UNPAGED: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && !pg_q) |-> !mem_req_valid); // R2
  AST_GATE_ON_FETCH: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mask_q[GATE_BIT]) |-> !mem_req_addr[GATE_BIT]); // R3
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (phys_addr == '0 && page_size == 2'd0)); // R9
  AST_FETCH_WIDTH: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_wide == pae_q)); // R7
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  localparam int PA_W = 36;

  typedef struct packed {
    logic [PA_W-1:0] pa;
    logic [1:0]      sz;
    logic            flt;
  } res_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            a20_wr_en = 1'b0;
  logic [31:0]     a20_wr_data = '0;
  logic            start = 1'b0;
  logic [31:0]     lin_addr = '0;
  logic            cr0_pg = 1'b0;
  logic [31:0]     cr3 = '0;
  logic            cr4_pae = 1'b0;
  logic            cr4_pse = 1'b0;
  logic            smm_mode = 1'b0;
  logic            mem_req_valid;
  logic            mem_req_ready = 1'b0;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_req_wide;
  logic            mem_rsp_valid = 1'b0;
  logic [63:0]     mem_rsp_data = '0;
  logic            done;
  logic [PA_W-1:0] phys_addr;
  logic [1:0]      page_size;
  logic            fault;

  always #2.5 clk = ~clk;

  pt_walker #(.PA_W(PA_W)) dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  int done_cnt = 0;
  logic [31:0] cur_mask = 32'hFFFF_FFFF;

  logic [63:0]     mem [logic [PA_W-1:0]];
  logic [PA_W-1:0] exp_addr_q [$];
  logic            exp_wide_q [$];
  string           exp_atag_q [$];
  res_t            exp_res_q  [$];
  string           exp_rtag_q [$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [PA_W-1:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // Reference walk built from the requirements
  task automatic model(input logic [31:0] lin, input bit pg, input logic [31:0] c3,
                       input bit pae, input bit pse, input bit smm, input string tag);
    logic [PA_W-1:0] pm, a, e, off, lx;
    res_t r;
    pm = smm ? '1 : {{(PA_W-32){cur_mask[31]}}, cur_mask};
    lx = PA_W'(lin);
    r  = '0;
    if (!pg) begin
      r.pa = lx & pm;
      exp_res_q.push_back(r); exp_rtag_q.push_back(tag);
      return;
    end
    if (!pae) begin
      a = (PA_W'(c3 & ~32'hFFF) + PA_W'((lin >> 20) & 32'hFFC)) & pm;
      exp_addr_q.push_back(a); exp_wide_q.push_back(1'b0); exp_atag_q.push_back("R4");
      e = PA_W'(rd(a) & 64'hFFFF_FFFF);
      if (!e[0]) begin r.flt = 1; exp_res_q.push_back(r); exp_rtag_q.push_back(tag); return; end
      if (pse && e[7]) begin
        off = PA_W'(32'h003F_FFFF); r.sz = 2'd2;
      end else begin
        a = (PA_W'(e[31:0] & ~32'hFFF) + PA_W'((lin >> 10) & 32'hFFC)) & pm;
        exp_addr_q.push_back(a); exp_wide_q.push_back(1'b0); exp_atag_q.push_back("R5");
        e = PA_W'(rd(a) & 64'hFFFF_FFFF);
        if (!e[0]) begin r.flt = 1; exp_res_q.push_back(r); exp_rtag_q.push_back(tag); return; end
        off = PA_W'(32'hFFF); r.sz = 2'd0;
      end
    end else begin
      a = (PA_W'(c3 & ~32'h1F) + PA_W'((lin >> 27) & 32'h18)) & pm;
      exp_addr_q.push_back(a); exp_wide_q.push_back(1'b1); exp_atag_q.push_back("R7");
      e = rd(a)[PA_W-1:0];
      if (!e[0]) begin r.flt = 1; exp_res_q.push_back(r); exp_rtag_q.push_back(tag); return; end
      a = ((e & ~PA_W'(12'hFFF)) + (PA_W'(lin[29:21]) << 3)) & pm;
      exp_addr_q.push_back(a); exp_wide_q.push_back(1'b1); exp_atag_q.push_back("R8");
      e = rd(a)[PA_W-1:0];
      if (!e[0]) begin r.flt = 1; exp_res_q.push_back(r); exp_rtag_q.push_back(tag); return; end
      if (e[7]) begin
        off = PA_W'(32'h001F_FFFF); r.sz = 2'd1;
      end else begin
        a = ((e & ~PA_W'(12'hFFF)) + (PA_W'(lin[20:12]) << 3)) & pm;
        exp_addr_q.push_back(a); exp_wide_q.push_back(1'b1); exp_atag_q.push_back("R8");
        e = rd(a)[PA_W-1:0];
        if (!e[0]) begin r.flt = 1; exp_res_q.push_back(r); exp_rtag_q.push_back(tag); return; end
        off = PA_W'(32'hFFF); r.sz = 2'd0;
      end
    end
    r.pa = ((e & pm) & ~off) | (lx & off);
    exp_res_q.push_back(r); exp_rtag_q.push_back(tag);
  endtask

  task automatic walk(input logic [31:0] lin, input bit pg, input logic [31:0] c3,
                      input bit pae, input bit pse, input bit smm, input string tag);
    int c0;
    model(lin, pg, c3, pae, pse, smm, tag);
    c0 = done_cnt;
    @(negedge clk);
    lin_addr = lin; cr0_pg = pg; cr3 = c3; cr4_pae = pae; cr4_pse = pse; smm_mode = smm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done_cnt == c0) @(negedge clk);
  endtask

  task automatic set_mask(input logic [31:0] m);
    @(negedge clk);
    a20_wr_en = 1'b1; a20_wr_data = m;
    @(negedge clk);
    a20_wr_en = 1'b0;
    cur_mask = m;
  endtask

  // Memory responder: checks each accepted fetch against the expected queue
  int pend = 0;
  logic [63:0] rdat = '0;
  always @(negedge clk) begin
    if (rst) begin
      mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; pend = 0;
    end else begin
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = rdat; end
      end
      mem_req_ready = ($urandom_range(0, 2) != 0);
      if (mem_req_valid && mem_req_ready) begin
        if (exp_addr_q.size() == 0) begin
          check(1'b0, "R9", "unexpected fetch", 64'(mem_req_addr), 64'h0);
        end else begin
          logic [PA_W-1:0] ea;
          logic ew;
          string et;
          ea = exp_addr_q.pop_front(); ew = exp_wide_q.pop_front(); et = exp_atag_q.pop_front();
          check(mem_req_addr == ea, et, "fetch address", 64'(mem_req_addr), 64'(ea));
          check(mem_req_wide == ew, et, "fetch width", 64'(mem_req_wide), 64'(ew));
        end
        rdat = rd(mem_req_addr);
        if (!mem_req_wide) rdat = {32'hDEAD_BEEF, rdat[31:0]};
        pend = $urandom_range(1, 2);
      end
    end
  end

  // Monitor: compares each result against the scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (prev_done) check(1'b0, "R11", "done longer than one cycle", 64'h1, 64'h0);
        if (exp_res_q.size() == 0) begin
          check(1'b0, "R11", "unexpected done", 64'h1, 64'h0);
        end else begin
          res_t er;
          string t;
          er = exp_res_q.pop_front(); t = exp_rtag_q.pop_front();
          check(phys_addr == er.pa, t, "phys_addr", 64'(phys_addr), 64'(er.pa));
          check(page_size == er.sz, t, "page_size", 64'(page_size), 64'(er.sz));
          check(fault == er.flt, t, "fault", 64'(fault), 64'(er.flt));
          check(exp_addr_q.size() == 0, t, "fetches left unissued", 64'(exp_addr_q.size()), 64'h0);
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // Two-level tables
    mem[36'h1004]      = 64'h0000_2003;
    mem[36'h200C]      = 64'h0055_5001;
    mem[36'h100C]      = 64'h0080_0083;
    mem[36'h0080_0048] = 64'h0077_7001;
    // Three-level tables
    mem[36'h3028] = 64'h0000_4001;
    mem[36'h4018] = 64'h0000_5001;
    mem[36'h5028] = 64'h8000_0009_ABCD_E001;
    mem[36'h3020] = 64'h0000_6001;
    mem[36'h6018] = 64'h0000_0001_2340_0081;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", 64'(done), 64'h0);
    check(mem_req_valid == 1'b0, "R1", "req valid after reset", 64'(mem_req_valid), 64'h0);

    walk(32'h0012_3456, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R1");   // reset mask keeps bit 20
    walk(32'hFFFF_F000, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, "R2");
    set_mask(32'hFFEF_FFFF);
    walk(32'h0013_5678, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, "R3");   // gated
    walk(32'h0013_5678, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, "R3");   // bypassed
    set_mask(32'hFFFF_FFFF);

    walk(32'h0040_3ABC, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "R5");
    walk(32'h00C1_2345, 1'b1, 32'h0000_1000, 1'b0, 1'b1, 1'b0, "R6");  // 4 MB
    walk(32'h00C1_2345, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "R6");  // PS ignored
    walk(32'h0080_0000, 1'b1, 32'h0000_1000, 1'b0, 1'b0, 1'b0, "R9");  // PDE absent

    walk(32'h4060_5123, 1'b1, 32'h0000_3020, 1'b1, 1'b0, 1'b0, "R10"); // 4 KB above 4 GB
    walk(32'h0060_0ABC, 1'b1, 32'h0000_3020, 1'b1, 1'b0, 1'b0, "R8");  // 2 MB
    walk(32'hC000_0000, 1'b1, 32'h0000_3020, 1'b1, 1'b0, 1'b0, "R9");  // PDPT absent
    walk(32'h0080_0000, 1'b1, 32'h0000_3020, 1'b1, 1'b0, 1'b0, "R9");  // PD absent

    set_mask(32'hFFEF_FFFF);
    walk(32'h0040_3ABC, 1'b1, 32'h0010_1000, 1'b0, 1'b0, 1'b0, "R3");  // gate hits tables
    walk(32'h0040_3ABC, 1'b1, 32'h0010_1000, 1'b0, 1'b0, 1'b1, "R3");  // bypass misses
    walk(32'h0060_0ABC, 1'b1, 32'h0000_3020, 1'b1, 1'b0, 1'b0, "R10");
    set_mask(32'hFFFF_FFFF);

    repeat (5) @(negedge clk);
    check(exp_res_q.size() == 0, "R11", "results outstanding", 64'(exp_res_q.size()), 64'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule